// File: doc/BRIEF.md
# Cache Request Issue and Retry Controller

This block sits between a pipeline memory stage and a cache port. It takes one memory operation at a time, described by a write flag, a load-linked/store-conditional flag, a swap flag, an address and store data. It turns the operation into a cache command and presents it on a valid/accept request port. When the cache turns the request down, the block keeps the request and waits for a retry pulse. An accepted request waits for the cache response. Completion is reported as a one-cycle pulse that carries the returned data, a writeback flag and a store-conditional success flag.

A reservation register (a valid bit plus an address) is set by the response to a load-linked operation. Every store-conditional checks this register. A store-conditional whose reservation is missing or points at another address never reaches the cache. It completes on its own with a failure result. Every store-conditional clears the reservation. The pipeline can squash the request in flight. Its response is still consumed and completes the operation, but it carries no data and sets no reservation.

Top module: `cmd_issue_ctrl`

## Requirements
- R1: A read (write flag low) is issued with command code 1 (load-locked) when the LL/SC flag is set and code 0 (plain read) otherwise; the swap flag has no effect on reads.
- R2: A write is issued with code 4 (swap) when the swap flag is set, regardless of the LL/SC flag; otherwise code 3 (store-conditional) when LL/SC is set, and code 2 (plain write) otherwise.
- R3: A store-conditional without a valid reservation for exactly its address makes no cache request; one cycle after it is taken, the completion pulse is high with the success flag low and the writeback flag low.
- R4: A load-locked response that was not squashed records a valid reservation for that request's address; a store-conditional succeeds only against a valid reservation with an equal address, and every store-conditional, successful or not, clears the reservation.
- R5: A request presented while the accept input is low is withdrawn on the next cycle and the block waits; a retry pulse re-presents the same command, address and data on the following cycle, and this repeats for each rejection.
- R6: A request taken with the accept input high moves the block to wait for the response; one cycle after the response the completion pulse is high for exactly one cycle, with the writeback flag and the response data for read, load-locked and swap commands, the writeback flag low and data zero for writes and store-conditionals, and the success flag high only for a store-conditional.
- R7: A squash input pulse while a request is outstanding makes its completion carry writeback low, data zero and success low, and the squashed response sets no reservation.
- R8: Only one operation is outstanding; the ready output is high only when idle, and an operation offered while busy is ignored and never issued.
- R9: After reset the request valid, completion pulse and reservation are clear and the ready output is high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| op_valid | input | 1 | Operation offered (taken only while op_ready is high) |
| op_write | input | 1 | 1 = write-type operation, 0 = read-type |
| op_llsc | input | 1 | Load-linked / store-conditional flag |
| op_swap | input | 1 | Swap flag for writes |
| op_addr | input | AW | Operation address |
| op_wdata | input | DW | Store data |
| op_squash | input | 1 | Squash the outstanding request |
| op_ready | output | 1 | Block is idle and takes an operation |
| cache_req_valid | output | 1 | Request presented to the cache |
| cache_req_cmd | output | 3 | Command code (0 read, 1 load-locked, 2 write, 3 store-conditional, 4 swap) |
| cache_req_addr | output | AW | Request address |
| cache_req_data | output | DW | Request data |
| cache_accept | input | 1 | Cache takes the request in this cycle |
| cache_retry | input | 1 | Cache invites a rejected request again |
| cache_resp_valid | input | 1 | Cache response for the outstanding request |
| cache_resp_data | input | DW | Response data |
| done_valid | output | 1 | Operation complete (one-cycle pulse) |
| done_data | output | DW | Returned data when written back, else zero |
| done_wb | output | 1 | Returned data is to be written back |
| done_sc_ok | output | 1 | Store-conditional succeeded |

## Verification
On every cycle the assertions check these properties: the command mapping for swap and load-locked operations, that a rejection is withdrawn into the retry wait, that a held request does not change while it waits, that an accept leads to the response wait, that a dropped store-conditional completes without a request, and that a squashed response never raises writeback. Some behaviour only the bench scenarios can show. The reservation must carry from a load-locked response to a later store-conditional, and it must be cleared after a store-conditional has used it. A squashed load-locked must leave no usable reservation. Multiple rejections in a row, and an operation ignored while busy, are also shown there.

// File: rtl/cic_pkg.sv
package cic_pkg;

  typedef enum logic [2:0] {
    CMD_READ       = 3'd0,
    CMD_LOAD_LOCK  = 3'd1,
    CMD_WRITE      = 3'd2,
    CMD_STORE_COND = 3'd3,
    CMD_SWAP       = 3'd4
  } cmd_e;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_ISSUE,
    ST_WAIT_RETRY,
    ST_WAIT_RESP
  } state_e;

  // Commands whose response carries data for the pipeline
  function automatic logic returns_data(cmd_e c);
    return (c == CMD_READ) || (c == CMD_LOAD_LOCK) || (c == CMD_SWAP);
  endfunction

endpackage

// File: rtl/cic_cmd_encode.sv
module cic_cmd_encode
  import cic_pkg::*;
(
  input  logic is_write,
  input  logic llsc,
  input  logic swap,
  output cmd_e cmd
);

  // Swap wins over LL/SC on writes; reads ignore swap
  always_comb begin
    if (!is_write)
      cmd = llsc ? CMD_LOAD_LOCK : CMD_READ;
    else if (swap)
      cmd = CMD_SWAP;
    else if (llsc)
      cmd = CMD_STORE_COND;
    else
      cmd = CMD_WRITE;
  end

endmodule

// File: rtl/cic_reservation.sv
module cic_reservation #(
  parameter int AW = 32
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          set_en,
  input  logic [AW-1:0] set_addr,
  input  logic          clear_en,
  input  logic [AW-1:0] chk_addr,
  output logic          hit
);

  logic          valid_q;
  logic [AW-1:0] addr_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      valid_q <= 1'b0;
      addr_q  <= '0;
    end else if (clear_en) begin
      valid_q <= 1'b0;
    end else if (set_en) begin
      valid_q <= 1'b1;
      addr_q  <= set_addr;
    end
  end

  assign hit = valid_q && (addr_q == chk_addr);

  // R4: a recorded reservation matches the address it was set with
  p_set_records_r4: assert property (@(posedge clk) disable iff (rst)
    (set_en && !clear_en) |=> (valid_q && addr_q == $past(set_addr)));

  // R4: a store-conditional leaves no reservation behind
  p_clear_drops_r4: assert property (@(posedge clk) disable iff (rst)
    clear_en |=> !valid_q);

endmodule

// File: rtl/cmd_issue_ctrl.sv
module cmd_issue_ctrl
  import cic_pkg::*;
#(
  parameter int AW = 32,
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          op_valid,
  input  logic          op_write,
  input  logic          op_llsc,
  input  logic          op_swap,
  input  logic [AW-1:0] op_addr,
  input  logic [DW-1:0] op_wdata,
  input  logic          op_squash,
  output logic          op_ready,
  output logic          cache_req_valid,
  output logic [2:0]    cache_req_cmd,
  output logic [AW-1:0] cache_req_addr,
  output logic [DW-1:0] cache_req_data,
  input  logic          cache_accept,
  input  logic          cache_retry,
  input  logic          cache_resp_valid,
  input  logic [DW-1:0] cache_resp_data,
  output logic          done_valid,
  output logic [DW-1:0] done_data,
  output logic          done_wb,
  output logic          done_sc_ok
);

  state_e        st;
  cmd_e          cmd_q;
  cmd_e          enc_cmd;
  logic [AW-1:0] addr_q;
  logic [DW-1:0] data_q;
  logic          killed_q;
  logic          req_valid_q;
  logic          done_valid_q;
  logic [DW-1:0] done_data_q;
  logic          done_wb_q;
  logic          done_sc_ok_q;

  logic take, in_is_sc, resv_hit, sc_drop, kill_now, resp_now, resv_set;

  cic_cmd_encode u_enc (
    .is_write (op_write),
    .llsc     (op_llsc),
    .swap     (op_swap),
    .cmd      (enc_cmd)
  );

  assign take     = (st == ST_IDLE) && op_valid;
  assign in_is_sc = (enc_cmd == CMD_STORE_COND);
  assign sc_drop  = take && in_is_sc && !resv_hit;
  assign kill_now = killed_q || op_squash;
  assign resp_now = (st == ST_WAIT_RESP) && cache_resp_valid;
  assign resv_set = resp_now && (cmd_q == CMD_LOAD_LOCK) && !kill_now;

  cic_reservation #(.AW(AW)) u_resv (
    .clk      (clk),
    .rst      (rst),
    .set_en   (resv_set),
    .set_addr (addr_q),
    .clear_en (take && in_is_sc),
    .chk_addr (op_addr),
    .hit      (resv_hit)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      st           <= ST_IDLE;
      cmd_q        <= CMD_READ;
      addr_q       <= '0;
      data_q       <= '0;
      killed_q     <= 1'b0;
      req_valid_q  <= 1'b0;
      done_valid_q <= 1'b0;
      done_data_q  <= '0;
      done_wb_q    <= 1'b0;
      done_sc_ok_q <= 1'b0;
    end else begin
      done_valid_q <= 1'b0;
      done_wb_q    <= 1'b0;
      done_sc_ok_q <= 1'b0;
      if (st != ST_IDLE && op_squash)
        killed_q <= 1'b1;
      unique case (st)
        ST_IDLE: begin
          if (take) begin
            killed_q <= 1'b0;
            if (sc_drop) begin
              done_valid_q <= 1'b1;
              done_data_q  <= '0;
            end else begin
              cmd_q       <= enc_cmd;
              addr_q      <= op_addr;
              data_q      <= op_wdata;
              req_valid_q <= 1'b1;
              st          <= ST_ISSUE;
            end
          end
        end
        ST_ISSUE: begin
          req_valid_q <= 1'b0;
          st          <= cache_accept ? ST_WAIT_RESP : ST_WAIT_RETRY;
        end
        ST_WAIT_RETRY: begin
          if (cache_retry) begin
            req_valid_q <= 1'b1;
            st          <= ST_ISSUE;
          end
        end
        ST_WAIT_RESP: begin
          if (cache_resp_valid) begin
            done_valid_q <= 1'b1;
            done_wb_q    <= returns_data(cmd_q) && !kill_now;
            done_data_q  <= (returns_data(cmd_q) && !kill_now) ? cache_resp_data : '0;
            done_sc_ok_q <= (cmd_q == CMD_STORE_COND) && !kill_now;
            st           <= ST_IDLE;
          end
        end
        default: st <= ST_IDLE;
      endcase
    end
  end

  assign op_ready        = (st == ST_IDLE);
  assign cache_req_valid = req_valid_q;
  assign cache_req_cmd   = cmd_q;
  assign cache_req_addr  = addr_q;
  assign cache_req_data  = data_q;
  assign done_valid      = done_valid_q;
  assign done_data       = done_data_q;
  assign done_wb         = done_wb_q;
  assign done_sc_ok      = done_sc_ok_q;

  // R1: load-locked read lands as load-locked command
  p_ll_map_r1: assert property (@(posedge clk) disable iff (rst)
    (take && !op_write && op_llsc) |=> (cmd_q == CMD_LOAD_LOCK && req_valid_q));

  // R2: swap overrides every other write flavour
  p_swap_map_r2: assert property (@(posedge clk) disable iff (rst)
    (take && op_write && op_swap) |=> (cmd_q == CMD_SWAP && req_valid_q));

  // R3: dropped store-conditional completes without touching the cache
  p_sc_drop_r3: assert property (@(posedge clk) disable iff (rst)
    sc_drop |=> (done_valid_q && !done_sc_ok_q && !req_valid_q));

  // R5: rejection withdraws the request into the retry wait
  p_reject_wait_r5: assert property (@(posedge clk) disable iff (rst)
    (req_valid_q && !cache_accept) |=> (st == ST_WAIT_RETRY && !req_valid_q));

  // R5: the held request is unchanged while waiting for retry
  p_retry_hold_r5: assert property (@(posedge clk) disable iff (rst)
    (st == ST_WAIT_RETRY) |=> ($stable(cmd_q) && $stable(addr_q) && $stable(data_q)));

  // R6: an accepted request waits for its response
  p_accept_resp_r6: assert property (@(posedge clk) disable iff (rst)
    (req_valid_q && cache_accept) |=> (st == ST_WAIT_RESP));

  // R7: squashed response never writes back
  p_squash_nowb_r7: assert property (@(posedge clk) disable iff (rst)
    (resp_now && kill_now) |=> (done_valid_q && !done_wb_q && !done_sc_ok_q));

  // R8: the captured operation cannot change while busy
  p_busy_hold_r8: assert property (@(posedge clk) disable iff (rst)
    (st != ST_IDLE) |=> $stable(addr_q));

endmodule

// File: tb/test_cmd_issue_ctrl.sv
module test_cmd_issue_ctrl;
  localparam int AW = 32;
  localparam int DW = 32;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          op_valid = 0, op_write = 0, op_llsc = 0, op_swap = 0, op_squash = 0;
  logic [AW-1:0] op_addr = '0;
  logic [DW-1:0] op_wdata = '0;
  logic          op_ready, cache_req_valid;
  logic [2:0]    cache_req_cmd;
  logic [AW-1:0] cache_req_addr;
  logic [DW-1:0] cache_req_data;
  logic          cache_accept = 0, cache_retry = 0, cache_resp_valid = 0;
  logic [DW-1:0] cache_resp_data = '0;
  logic          done_valid, done_wb, done_sc_ok;
  logic [DW-1:0] done_data;

  int n_checks = 0;
  int n_fail   = 0;
  int cycles   = 0;

  always #4 clk = ~clk;  // 125 MHz

  cmd_issue_ctrl #(.AW(AW), .DW(DW)) i_cmd_issue_ctrl (
    .clk, .rst, .op_valid, .op_write, .op_llsc, .op_swap, .op_addr, .op_wdata,
    .op_squash, .op_ready, .cache_req_valid, .cache_req_cmd, .cache_req_addr,
    .cache_req_data, .cache_accept, .cache_retry, .cache_resp_valid,
    .cache_resp_data, .done_valid, .done_data, .done_wb, .done_sc_ok
  );

  typedef struct packed {
    logic        w, l, s;
    logic [15:0] addr;
    logic [15:0] data;
    logic [2:0]  cmd;
    logic        issue;
    logic [1:0]  rej;
    logic [15:0] resp;
    logic        kill;
    logic        wb;
    logic        sc;
  } vec_t;

  // w l s addr data cmd issue rej resp kill wb sc
  localparam int NV = 11;
  localparam vec_t VECS [NV] = '{
    '{1'b0,1'b0,1'b0,16'h0010,16'h0000,3'd0,1'b1,2'd0,16'hAAAA,1'b0,1'b1,1'b0}, // R1 read
    '{1'b0,1'b1,1'b0,16'h0020,16'h0000,3'd1,1'b1,2'd1,16'h1111,1'b0,1'b1,1'b0}, // R1 LL, R5 reject
    '{1'b1,1'b1,1'b0,16'h0020,16'h2222,3'd3,1'b1,2'd0,16'h9999,1'b0,1'b0,1'b1}, // R4 SC ok
    '{1'b1,1'b1,1'b0,16'h0020,16'h3333,3'd3,1'b0,2'd0,16'h0000,1'b0,1'b0,1'b0}, // R4 cleared
    '{1'b1,1'b0,1'b0,16'h0030,16'h4444,3'd2,1'b1,2'd2,16'h7777,1'b0,1'b0,1'b0}, // R2 write, R5
    '{1'b1,1'b1,1'b1,16'h0034,16'h5151,3'd4,1'b1,2'd0,16'h5555,1'b0,1'b1,1'b0}, // R2 swap
    '{1'b0,1'b1,1'b0,16'h0040,16'h0000,3'd1,1'b1,2'd0,16'h6666,1'b0,1'b1,1'b0}, // R1 LL
    '{1'b1,1'b1,1'b0,16'h0044,16'h0808,3'd3,1'b0,2'd0,16'h0000,1'b0,1'b0,1'b0}, // R3 mismatch
    '{1'b0,1'b1,1'b0,16'h0050,16'h0000,3'd1,1'b1,2'd0,16'hBEEF,1'b1,1'b0,1'b0}, // R7 squash
    '{1'b1,1'b1,1'b0,16'h0050,16'h0909,3'd3,1'b0,2'd0,16'h0000,1'b0,1'b0,1'b0}, // R7 no resv
    '{1'b0,1'b0,1'b1,16'h0060,16'h0000,3'd0,1'b1,2'd0,16'hCAFE,1'b0,1'b1,1'b0}  // R1 swap ignored
  };

  task automatic chk(input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic report();
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  endtask

  task automatic run_op(input vec_t v, input string req);
    chk(req, "ready before op", op_ready, 1);
    op_valid = 1; op_write = v.w; op_llsc = v.l; op_swap = v.s;
    op_addr = 32'(v.addr); op_wdata = 32'(v.data);
    @(negedge clk);
    op_valid = 0;
    if (!v.issue) begin
      chk(req, "drop no request", cache_req_valid, 0);
      chk(req, "drop done", done_valid, 1);
      chk(req, "drop sc_ok", done_sc_ok, 0);
      chk(req, "drop wb", done_wb, 0);
      @(negedge clk);
      return;
    end
    chk(req, "req valid", cache_req_valid, 1);
    chk(req, "req cmd", 32'(cache_req_cmd), 32'(v.cmd));
    chk(req, "req addr", cache_req_addr, 32'(v.addr));
    for (int i = 0; i < int'(v.rej); i++) begin
      @(negedge clk);
      chk("R5", "withdrawn after reject", cache_req_valid, 0);
      @(negedge clk);
      chk("R5", "still waiting", cache_req_valid, 0);
      cache_retry = 1;
      @(negedge clk);
      cache_retry = 0;
      chk("R5", "reissue valid", cache_req_valid, 1);
      chk("R5", "reissue cmd", 32'(cache_req_cmd), 32'(v.cmd));
      chk("R5", "reissue data", cache_req_data, 32'(v.data));
    end
    cache_accept = 1;
    @(negedge clk);
    cache_accept = 0;
    chk(req, "req dropped after accept", cache_req_valid, 0);
    chk("R8", "busy not ready", op_ready, 0);
    if (v.kill) begin
      op_squash = 1;
      @(negedge clk);
      op_squash = 0;
    end
    cache_resp_valid = 1; cache_resp_data = 32'(v.resp);
    @(negedge clk);
    cache_resp_valid = 0;
    chk(req, "done", done_valid, 1);
    chk(req, "wb", done_wb, v.wb);
    chk(req, "data", done_data, v.wb ? 32'(v.resp) : 32'h0);
    chk(req, "sc_ok", done_sc_ok, v.sc);
    @(negedge clk);
    chk("R6", "done one cycle", done_valid, 0);
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 20000) begin
      n_checks++; n_fail++;
      $display("FAIL watchdog: actual=%0d expected<=20000 cycles", cycles);
      report();
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R9: reset state
    chk("R9", "req valid in reset", cache_req_valid, 0);
    rst = 0;
    @(negedge clk);
    chk("R9", "ready", op_ready, 1);
    chk("R9", "no request", cache_req_valid, 0);
    chk("R9", "no done", done_valid, 0);
    // R9: reservation clear -> SC dropped
    run_op('{1'b1,1'b1,1'b0,16'h0000,16'h0001,3'd3,1'b0,2'd0,16'h0,1'b0,1'b0,1'b0}, "R9");

    for (int k = 0; k < NV; k++) run_op(VECS[k], $sformatf("R%0d", k < 1 ? 1 : 2));

    // R8: an operation offered while busy is ignored
    op_valid = 1; op_write = 0; op_llsc = 1; op_swap = 0; op_addr = 32'h80;
    @(negedge clk);
    op_valid = 0;
    cache_accept = 1;
    @(negedge clk);
    cache_accept = 0;
    op_valid = 1; op_write = 1; op_llsc = 0; op_addr = 32'h90;
    chk("R8", "not ready while busy", op_ready, 0);
    @(negedge clk);
    chk("R8", "no second request", cache_req_valid, 0);
    op_valid = 0;
    cache_resp_valid = 1; cache_resp_data = 32'h1234;
    @(negedge clk);
    cache_resp_valid = 0;
    chk("R6", "LL done data", done_data, 32'h1234);
    @(negedge clk);
    chk("R8", "ignored op never issued", cache_req_valid, 0);
    chk("R8", "ready again", op_ready, 1);
    // R4: reservation from that LL allows a matching SC
    run_op('{1'b1,1'b1,1'b0,16'h0080,16'h0055,3'd3,1'b1,2'd0,16'h0,1'b0,1'b0,1'b1}, "R4");

    // R5: retry rejected again stays waiting
    op_valid = 1; op_write = 1; op_llsc = 0; op_swap = 0; op_addr = 32'hA0; op_wdata = 32'h77;
    @(negedge clk);
    op_valid = 0;
    @(negedge clk);
    chk("R5", "rejected", cache_req_valid, 0);
    cache_retry = 1;
    @(negedge clk);
    cache_retry = 0;
    chk("R5", "retry reissues", cache_req_valid, 1);
    @(negedge clk);
    chk("R5", "second reject waits", cache_req_valid, 0);
    chk("R5", "still busy", op_ready, 0);
    cache_retry = 1;
    @(negedge clk);
    cache_retry = 0;
    cache_accept = 1;
    chk("R5", "addr held", cache_req_addr, 32'hA0);
    @(negedge clk);
    cache_accept = 0;
    cache_resp_valid = 1;
    @(negedge clk);
    cache_resp_valid = 0;
    chk("R6", "write completes", done_valid, 1);
    chk("R6", "write no wb", done_wb, 0);
    @(negedge clk);
    report();
  end

endmodule